// File: doc/BRIEF.md
# SIMD Narrowing High-Half Add/Subtract Unit

This block takes two 128-bit vector operands and returns one 64-bit vector. The operands are split into wide lanes of 16, 32 or 64 bits. Each pair of lanes is added or subtracted at full lane width. Only the upper half of each wide result is kept, so every lane shrinks to half its width. The narrowed lanes from the lower 64 bits of the operands fill the lower half of the result, and those from the upper 64 bits fill the upper half.

An optional rounding mode adds a bias of half of one narrow unit to each wide lane before it is truncated. The controls arrive already decoded: add or subtract, round enable, a 2-bit element-size code and a valid strobe. The result is registered. A size code with no meaning raises an error flag and produces no result.

Top module: `vnarrow_hi`

## Requirements
- R1: While reset is held and on the first clock after it, `res_o`, `res_valid_o` and `size_err_o` are all zero.
- R2: Size code 0 treats each operand as eight 16-bit lanes, and each result byte is bits [15:8] of the matching lane's wide result.
- R3: Size code 1 treats each operand as four 32-bit lanes, and each 16-bit result field is bits [31:16] of the matching lane's wide result.
- R4: Size code 2 treats each operand as two 64-bit lanes, and each 32-bit result field is bits [63:32] of the matching lane's wide result.
- R5: Result lane i comes from operand lane i. Operand bits [63:0] therefore produce `res_o[31:0]`, and operand bits [127:64] produce `res_o[63:32]`.
- R6: With `op_sub`=1 the wide result is `src_a` lane minus `src_b` lane, modulo 2^lane width. With `op_sub`=0 it is the sum, modulo 2^lane width. The narrowing step is the same in both cases.
- R7: With `op_round`=1, the value 2^(narrow width − 1) is added to each wide result before truncation. This addition wraps inside the lane, so a wide result of all ones yields zero.
- R8: Carries and borrows never cross a lane boundary.
- R9: A strobe with size code 3 gives `size_err_o`=1 and `res_valid_o`=0 on the next cycle, and `res_o` keeps its previous value.
- R10: A strobe with size code 0, 1 or 2 gives `res_valid_o`=1 and the new `res_o` exactly one cycle later. In a cycle with no strobe, both flags drop on the next cycle and `res_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| op_round | input | 1 | 1 = add rounding bias before truncation |
| elem_size | input | 2 | 0: 16→8, 1: 32→16, 2: 64→32, 3: invalid |
| src_a | input | 128 | First operand (minuend) |
| src_b | input | 128 | Second operand (subtrahend) |
| res_o | output | 64 | Packed narrowed result |
| res_valid_o | output | 1 | Result was updated this cycle |
| size_err_o | output | 1 | Last strobe carried size code 3 |

## Verification
The bench builds the block with its default half width of 64 bits. At that width all three lane sizes exist: 16, 32 and 64 bits. It also gives the rounding bias its widest case, 2^31, in the 64-bit lanes. The vectors are chosen so that carries arrive exactly at lane edges, wide results are all ones with rounding on, and each result lane holds a different value, so that any lane mis-ordering becomes visible at the 64-bit output.

// File: rtl/vnh_pkg.sv
package vnh_pkg;

    typedef enum logic [1:0] {
        NSZ_16TO8  = 2'd0,
        NSZ_32TO16 = 2'd1,
        NSZ_64TO32 = 2'd2,
        NSZ_BAD    = 2'd3
    } nsize_e;

    typedef struct packed {
        logic   sub;
        logic   rnd;
        nsize_e sz;
    } nctl_t;

    function automatic logic size_is_bad(input nsize_e sz);
        return sz == NSZ_BAD;
    endfunction

endpackage

// File: rtl/vnh_half_unit.sv
module vnh_half_unit
    import vnh_pkg::*;
#(
    parameter int HALF_W = 64,
    localparam int OUT_W = HALF_W / 2
) (
    input  logic [HALF_W-1:0] a,
    input  logic [HALF_W-1:0] b,
    input  nctl_t             ctl,
    output logic [OUT_W-1:0]  q
);

    logic [OUT_W-1:0] per_size [3];

    for (genvar k = 0; k < 3; k++) begin : g_size
        localparam int LW = HALF_W >> (2 - k);
        localparam int NW = LW / 2;
        localparam int NL = HALF_W / LW;
        localparam logic [LW-1:0] BIAS = (LW)'(1) << (NW - 1);

        logic [OUT_W-1:0] packed_k;

        for (genvar l = 0; l < NL; l++) begin : g_lane
            logic [LW-1:0] wide;
            logic [LW-1:0] biased;
            always_comb begin
                if (ctl.sub) wide = a[l*LW +: LW] - b[l*LW +: LW];
                else         wide = a[l*LW +: LW] + b[l*LW +: LW];
                biased = ctl.rnd ? wide + BIAS : wide;
            end
            assign packed_k[l*NW +: NW] = biased[LW-1:NW];
        end

        assign per_size[k] = packed_k;
    end

    always_comb begin
        unique case (ctl.sz)
            NSZ_16TO8:  q = per_size[0];
            NSZ_32TO16: q = per_size[1];
            NSZ_64TO32: q = per_size[2];
            default:    q = '0;
        endcase
    end

endmodule

// File: rtl/vnh_out_reg.sv
module vnh_out_reg #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe,
    input  logic         bad,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         vld,
    output logic         err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= '0;
            vld <= 1'b0;
            err <= 1'b0;
        end else begin
            vld <= strobe && !bad;
            err <= strobe && bad;
            if (strobe && !bad) q <= d;
        end
    end

endmodule

// File: rtl/vnarrow_hi.sv
module vnarrow_hi
    import vnh_pkg::*;
#(
    parameter int HALF_W = 64,
    localparam int IN_W  = 2 * HALF_W,
    localparam int OUT_W = HALF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             op_sub,
    input  logic             op_round,
    input  logic [1:0]       elem_size,
    input  logic [IN_W-1:0]  src_a,
    input  logic [IN_W-1:0]  src_b,
    output logic [OUT_W-1:0] res_o,
    output logic             res_valid_o,
    output logic             size_err_o
);

    localparam int HO_W = HALF_W / 2;

    nctl_t           ctl;
    logic [OUT_W-1:0] narrowed;

    assign ctl.sub = op_sub;
    assign ctl.rnd = op_round;
    assign ctl.sz  = nsize_e'(elem_size);

    for (genvar h = 0; h < 2; h++) begin : g_half
        vnh_half_unit #(.HALF_W(HALF_W)) u_half (
            .a   (src_a[h*HALF_W +: HALF_W]),
            .b   (src_b[h*HALF_W +: HALF_W]),
            .ctl (ctl),
            .q   (narrowed[h*HO_W +: HO_W])
        );
    end

    vnh_out_reg #(.W(OUT_W)) u_oreg (
        .clk    (clk),
        .rst    (rst),
        .strobe (in_valid),
        .bad    (size_is_bad(ctl.sz)),
        .d      (narrowed),
        .q      (res_o),
        .vld    (res_valid_o),
        .err    (size_err_o)
    );

endmodule

// File: rtl/vnarrow_hi_chk.sv
module vnarrow_hi_chk #(
    parameter int OUT_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [1:0]       elem_size,
    input logic [OUT_W-1:0] res_o,
    input logic             res_valid_o,
    input logic             size_err_o
);

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
        (in_valid && elem_size != 2'd3) |=> (res_valid_o && !size_err_o));

    a_r9_bad_size_flag: assert property (@(posedge clk) disable iff (rst)
        (in_valid && elem_size == 2'd3) |=> (size_err_o && !res_valid_o));

    a_r9_bad_size_hold: assert property (@(posedge clk) disable iff (rst)
        (in_valid && elem_size == 2'd3) |=> $stable(res_o));

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!res_valid_o && !size_err_o && $stable(res_o)));

    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(res_valid_o && size_err_o));

endmodule

bind vnarrow_hi vnarrow_hi_chk #(.OUT_W(OUT_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .elem_size   (elem_size),
    .res_o       (res_o),
    .res_valid_o (res_valid_o),
    .size_err_o  (size_err_o)
);

// File: tb/vnarrow_hi_tb_top.sv
module vnarrow_hi_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         op_sub;
    logic         op_round;
    logic [1:0]   elem_size;
    logic [127:0] src_a;
    logic [127:0] src_b;
    logic [63:0]  res_o;
    logic         res_valid_o;
    logic         size_err_o;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    vnarrow_hi dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub),
        .op_round(op_round), .elem_size(elem_size), .src_a(src_a),
        .src_b(src_b), .res_o(res_o), .res_valid_o(res_valid_o),
        .size_err_o(size_err_o)
    );

    typedef struct packed {
        logic [127:0] a;
        logic [127:0] b;
        logic         sub;
        logic         rnd;
        logic [1:0]   sz;
        logic [63:0]  exp;
        logic [7:0]   req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        // R2 size 0 add: 0x0180+0x0080=0x0200 -> 02
        '{{8{16'h0180}}, {8{16'h0080}}, 1'b0, 1'b0, 2'd0, {8{8'h02}}, 8'd2},
        // R7 size 0 no round: 0x0180 -> 01
        '{{8{16'h0100}}, {8{16'h0080}}, 1'b0, 1'b0, 2'd0, {8{8'h01}}, 8'd7},
        // R7 size 0 round: 0x0180+0x80=0x0200 -> 02
        '{{8{16'h0100}}, {8{16'h0080}}, 1'b0, 1'b1, 2'd0, {8{8'h02}}, 8'd7},
        // R6 size 0 sub: 0-0x0100=0xFF00 -> FF
        '{128'h0, {8{16'h0100}}, 1'b1, 1'b0, 2'd0, {8{8'hFF}}, 8'd6},
        // R7 wrap: 0xFFFF+0x80 wraps to 0x007F -> 00
        '{{8{16'hFFFF}}, 128'h0, 1'b0, 1'b1, 2'd0, 64'h0, 8'd7},
        // R8 size 1: 0xFFFF0000+0x00010000 wraps to 0, no carry into next lane
        '{{4{32'hFFFF_0000}}, {4{32'h0001_0000}}, 1'b0, 1'b0, 2'd1, 64'h0, 8'd8},
        // R3 size 1 add: 0x00038000+0x00018000=0x00050000 -> 0005
        '{{4{32'h0003_8000}}, {4{32'h0001_8000}}, 1'b0, 1'b0, 2'd1, {4{16'h0005}}, 8'd3},
        // R3 size 1 sub: 0x00010000-0x00020000=0xFFFF0000 -> FFFF
        '{{4{32'h0001_0000}}, {4{32'h0002_0000}}, 1'b1, 1'b0, 2'd1, {4{16'hFFFF}}, 8'd3},
        // R4 size 2 add with distinct halves (upper lane -> res[63:32])
        '{{64'h0000_0001_FFFF_FFFF, 64'h0000_0010_0000_0000},
          {64'h0000_0000_0000_0001, 64'h0000_0020_0000_0000},
          1'b0, 1'b0, 2'd2, 64'h0000_0002_0000_0030, 8'd4},
        // R4 size 2 round, bias 2^31
        '{{64'h0000_0005_7FFF_FFFF, 64'h0000_0007_8000_0000}, 128'h0,
          1'b0, 1'b1, 2'd2, 64'h0000_0005_0000_0008, 8'd4},
        // R6 size 2 sub: 0-1 = all ones -> FFFFFFFF
        '{128'h0, {2{64'h1}}, 1'b1, 1'b0, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 8'd6},
        // R5 lane order: byte i of result from 16-bit lane i
        '{128'h0800_0700_0600_0500_0400_0300_0200_0100, 128'h0,
          1'b0, 1'b0, 2'd0, 64'h0807_0605_0403_0201, 8'd5}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [127:0] a, input logic [127:0] b,
                         input logic sub, input logic rnd, input logic [1:0] sz);
        @(negedge clk);
        src_a = a; src_b = b; op_sub = sub; op_round = rnd; elem_size = sz;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [63:0] held;
        rst = 1'b1; in_valid = 1'b0; op_sub = 1'b0; op_round = 1'b0;
        elem_size = 2'd0; src_a = '0; src_b = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(res_o == 64'h0 && !res_valid_o && !size_err_o, "R1",
              {res_o[63:2], res_valid_o, size_err_o}, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        check(res_o == 64'h0 && !res_valid_o && !size_err_o, "R1",
              {res_o[63:2], res_valid_o, size_err_o}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].a, VECS[i].b, VECS[i].sub, VECS[i].rnd, VECS[i].sz);
            check(res_valid_o && !size_err_o, "R10 valid",
                  {62'h0, res_valid_o, size_err_o}, 64'h2);
            check(res_o == VECS[i].exp, $sformatf("R%0d vec %0d", VECS[i].req, i),
                  res_o, VECS[i].exp);
        end

        // R10 idle cycle: flags drop, result holds
        held = res_o;
        @(negedge clk);
        check(!res_valid_o && !size_err_o && res_o == held, "R10 idle",
              res_o, held);

        // R9 size code 3: error flag, no result
        issue({8{16'h7777}}, {8{16'h1111}}, 1'b0, 1'b0, 2'd3);
        check(size_err_o && !res_valid_o, "R9 flags",
              {62'h0, res_valid_o, size_err_o}, 64'h1);
        check(res_o == held, "R9 hold", res_o, held);

        // R10 back-to-back strobes update each cycle
        @(negedge clk);
        src_a = {8{16'h0300}}; src_b = '0; op_sub = 1'b0; op_round = 1'b0;
        elem_size = 2'd0; in_valid = 1'b1;
        @(negedge clk);
        check(res_valid_o && res_o == {8{8'h03}}, "R10 b2b first",
              res_o, {8{8'h03}});
        src_a = {8{16'h0400}};
        @(negedge clk);
        in_valid = 1'b0;
        check(res_valid_o && res_o == {8{8'h04}}, "R10 b2b second",
              res_o, {8{8'h04}});

        // R6 size 2 sub with round: all ones + 2^31 wraps, upper half 0
        issue(128'h0, {2{64'h1}}, 1'b1, 1'b1, 2'd2);
        check(res_o == 64'h0, "R7 wrap 64-bit lane", res_o, 64'h0);

        // R1 reset mid-run clears the outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(res_o == 64'h0 && !res_valid_o && !size_err_o, "R1 re-reset",
              res_o, 64'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule